// File: doc/BRIEF.md
# Dynamic re-reference interval replacement selector

This block keeps a 3-bit re-reference prediction per way for every set of a set-associative cache and names the way to replace. A value of 0 means the line is expected back soon. A value of 7 means it is expected far in the future and can be evicted. The tag and data arrays live outside the block. The surrounding cache controller reports each lookup with its set, whether it hit, and which way hit. It reads the proposed victim for the looked-up set in the same cycle. When the refill lands, it strobes the set and way that were written.

On a miss the set is aged in a single step, so that the chosen victim holds the maximum value. A fill writes an insertion value that depends on the active policy. The static policy always inserts at 7. The bimodal policy inserts at 6 once in a while, which lets a few lines survive a scan that would otherwise flush the whole set. A small group of leader sets is fixed to each policy. A saturating selector counter compares the misses in the two groups and picks the policy that all remaining sets follow.

Top module: `drrip_repl`

## Requirements
- R1: After reset every prediction value is 7. The selector counter is 2^(PSEL_W-1)-1, so `mode_bimodal` is 0 and `vict_way` is 0 for any set.
- R2: `vict_way` is combinational on `acc_set`. It is the lowest-numbered way among those holding the largest prediction value of that set.
- R3: A lookup with `acc_valid`=1 and `acc_hit`=1 sets the value of way `acc_way` in set `acc_set` to 0. The other ways of that set are left unchanged.
- R4: A lookup with `acc_valid`=1 and `acc_hit`=0 adds (7 − largest value of the set) to every way of `acc_set` at the same edge. Every other set is left unchanged.
- R5: A fill (`fill_valid`=1) to a set that uses the static policy writes 7 into way `fill_way` of set `fill_set`.
- R6: A fill to a set that uses the bimodal policy writes 6 when the low RARE_BITS bits of the random register are all zero before the fill, and writes 7 otherwise. The random register is 16 bits wide and is seeded with 0xACE1. On every fill it advances by shifting left, with (bit15 ^ bit13 ^ bit12 ^ bit10) entering at bit 0.
- R7: Let k = log2(SETS/LEADERS). A set whose low k index bits are all zero is a static leader. A set whose low k index bits are all ones is a bimodal leader. Every other set is a follower, and it uses the bimodal policy exactly when the counter's MSB is 1.
- R8: The PSEL_W-bit selector counter moves up by 1 on a miss in a static leader, saturating at all ones. It moves down by 1 on a miss in a bimodal leader, saturating at 0. `mode_bimodal` shows its MSB.
- R9: When a fill and a lookup act on the same set in the same cycle, the fill's value wins for the filled way. A miss still ages the other ways of that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Lookup result valid this cycle |
| acc_set | input | log2(SETS) | Set index of the lookup; also selects the set whose victim is shown |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | log2(WAYS) | Way that hit |
| fill_valid | input | 1 | A refill is written this cycle |
| fill_set | input | log2(SETS) | Set receiving the refill |
| fill_way | input | log2(WAYS) | Way receiving the refill |
| vict_way | output | log2(WAYS) | Way to replace in set `acc_set` |
| mode_bimodal | output | 1 | Follower policy: 1 = bimodal, 0 = static |

## Verification
The bench builds the block with 16 sets, 4 ways, 4 leaders per policy, a 4-bit selector and RARE_BITS=2. These values put leaders at every fourth set, so both saturation limits of the selector are reached within a handful of misses. They also make the rare insertion at 6 occur about once every four fills, so it shows up in short directed runs. With these values, the aging of sets that hold a mix of 6s, 7s and 0s and the effect of policy flips on followers can be exercised against the behavioural model on every cycle.

// File: rtl/drrip_pkg.sv
package drrip_pkg;
   localparam int RRPV_W = 3;
   typedef logic [RRPV_W-1:0] rrpv_t;
   localparam rrpv_t RRPV_MAX = '1;
   localparam rrpv_t RRPV_LONG = RRPV_MAX - rrpv_t'(1);

   typedef enum logic [1:0] {
      KIND_FOLLOW  = 2'd0,
      KIND_LEAD_ST = 2'd1,
      KIND_LEAD_BM = 2'd2
   } set_kind_e;
endpackage

// File: rtl/drrip_victim_sel.sv
module drrip_victim_sel
   import drrip_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS*RRPV_W-1:0] row_flat,
   output logic [WAY_W-1:0]       vict_way,
   output rrpv_t                  age_delta
);
   rrpv_t row_max;

   always_comb begin
      row_max = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (row_flat[w*RRPV_W +: RRPV_W] > row_max)
            row_max = row_flat[w*RRPV_W +: RRPV_W];
      end
   end

   always_comb begin
      vict_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (row_flat[w*RRPV_W +: RRPV_W] == row_max)
            vict_way = WAY_W'(w);
      end
   end

   assign age_delta = RRPV_MAX - row_max;
endmodule

// File: rtl/drrip_lfsr.sv
module drrip_lfsr #(
   parameter int          LFSR_W   = 16,
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter logic [15:0] TAP_MASK = 16'hB400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [LFSR_W-1:0] state
);
   if (LFSR_W != 16) begin : g_bad_width
      $error("drrip_lfsr: only a 16-bit register is supported");
   end

   logic fb;
   assign fb = ^(state & TAP_MASK[LFSR_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= SEED[LFSR_W-1:0];
      else if (step) state <= {state[LFSR_W-2:0], fb};
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);                                                      // R6
endmodule

// File: rtl/drrip_psel.sv
module drrip_psel #(
   parameter int CNT_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up,
   input  logic down,
   output logic msb
);
   localparam logic [CNT_W-1:0] CNT_TOP  = '1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_TOP >> 1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("drrip_psel: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt_q <= CNT_INIT;
      else if (up && cnt_q != CNT_TOP)     cnt_q <= cnt_q + 1'b1;
      else if (down && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
   end

   assign msb = cnt_q[CNT_W-1];

   AST_PSEL_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !down && cnt_q == CNT_TOP) |=> cnt_q == CNT_TOP);          // R8
   AST_PSEL_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (down && !up && cnt_q == '0) |=> cnt_q == '0);                   // R8
   AST_PSEL_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !down && cnt_q != CNT_TOP) |=> cnt_q == $past(cnt_q) + 1'b1); // R8
endmodule

// File: rtl/drrip_repl.sv
module drrip_repl
   import drrip_pkg::*;
#(
   parameter int SETS      = 256,
   parameter int WAYS      = 4,
   parameter int LEADERS   = 32,
   parameter int PSEL_W    = 10,
   parameter int RARE_BITS = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic [$clog2(SETS)-1:0]   acc_set,
   input  logic                      acc_hit,
   input  logic [$clog2(WAYS)-1:0]   acc_way,
   input  logic                      fill_valid,
   input  logic [$clog2(SETS)-1:0]   fill_set,
   input  logic [$clog2(WAYS)-1:0]   fill_way,
   output logic [$clog2(WAYS)-1:0]   vict_way,
   output logic                      mode_bimodal
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int LDR_W = $clog2(LEADERS);
   localparam int SEL_W = SET_W - LDR_W;
   localparam int LFSR_W = 16;

   if (SETS != (1 << SET_W) || WAYS != (1 << WAY_W) || LEADERS != (1 << LDR_W))
   begin : g_bad_pow2
      $error("drrip_repl: SETS, WAYS and LEADERS must be powers of two");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("drrip_repl: at least two ways are required");
   end
   if (SEL_W < 2) begin : g_bad_leaders
      $error("drrip_repl: SETS must be at least 4*LEADERS");
   end
   if (RARE_BITS < 1 || RARE_BITS > LFSR_W) begin : g_bad_rare
      $error("drrip_repl: RARE_BITS out of range");
   end

   function automatic set_kind_e kind_of(input logic [SET_W-1:0] idx);
      logic [SEL_W-1:0] low;
      low = idx[SEL_W-1:0];
      if (low == '0)      return KIND_LEAD_ST;
      else if (low == '1) return KIND_LEAD_BM;
      else                return KIND_FOLLOW;
   endfunction

   rrpv_t                 rrpv_q [SETS][WAYS];
   logic [WAYS*RRPV_W-1:0] row_flat;
   rrpv_t                 age_delta;
   logic [LFSR_W-1:0]     rnd;
   logic                  psel_msb;
   set_kind_e             acc_kind, fill_kind;
   logic                  use_bimodal, rare_hit;
   rrpv_t                 ins_val;

   for (genvar w = 0; w < WAYS; w++) begin : g_row
      assign row_flat[w*RRPV_W +: RRPV_W] = rrpv_q[acc_set][w];
   end

   drrip_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vsel (
      .row_flat (row_flat),
      .vict_way (vict_way),
      .age_delta(age_delta)
   );

   drrip_lfsr #(.LFSR_W(LFSR_W)) u_rnd (
      .clk  (clk),
      .rst_n(rst_n),
      .step (fill_valid),
      .state(rnd)
   );

   assign acc_kind  = kind_of(acc_set);
   assign fill_kind = kind_of(fill_set);

   drrip_psel #(.CNT_W(PSEL_W)) u_psel (
      .clk  (clk),
      .rst_n(rst_n),
      .up   (acc_valid && !acc_hit && acc_kind == KIND_LEAD_ST),
      .down (acc_valid && !acc_hit && acc_kind == KIND_LEAD_BM),
      .msb  (psel_msb)
   );

   assign mode_bimodal = psel_msb;
   assign use_bimodal  = (fill_kind == KIND_LEAD_BM) ||
                         (fill_kind == KIND_FOLLOW && psel_msb);
   assign rare_hit     = (rnd[RARE_BITS-1:0] == '0);
   assign ins_val      = (use_bimodal && rare_hit) ? RRPV_LONG : RRPV_MAX;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               rrpv_q[s][w] <= RRPV_MAX;
      end else begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               if (fill_valid && fill_set == SET_W'(s) && fill_way == WAY_W'(w))
                  rrpv_q[s][w] <= ins_val;
               else if (acc_valid && acc_set == SET_W'(s)) begin
                  if (!acc_hit)
                     rrpv_q[s][w] <= rrpv_q[s][w] + age_delta;
                  else if (acc_way == WAY_W'(w))
                     rrpv_q[s][w] <= '0;
               end
            end
         end
      end
   end

   AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit && !(fill_valid && fill_set == acc_set && fill_way == acc_way))
      |=> rrpv_q[$past(acc_set)][$past(acc_way)] == '0);               // R3
   AST_MISS_VICT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit && !(fill_valid && fill_set == acc_set))
      |=> rrpv_q[$past(acc_set)][$past(vict_way)] == RRPV_MAX);        // R4
   AST_FILL_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> rrpv_q[$past(fill_set)][$past(fill_way)] >= RRPV_LONG); // R6
   AST_STATIC_LEADER: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_kind == KIND_LEAD_ST)
      |=> rrpv_q[$past(fill_set)][$past(fill_way)] == RRPV_MAX);       // R7
endmodule

// File: tb/sim_drrip_repl.sv
module sim_drrip_repl;
   localparam int SETS = 16, WAYS = 4, LEADERS = 4, PSEL_W = 4, RARE_BITS = 2;
   localparam int SEL_MASK = (SETS / LEADERS) - 1;
   localparam int PSEL_TOP = (1 << PSEL_W) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0, acc_hit = 1'b0, fill_valid = 1'b0;
   logic [3:0] acc_set = '0, fill_set = '0;
   logic [1:0] acc_way = '0, fill_way = '0;
   logic [1:0] vict_way;
   logic       mode_bimodal;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   int mv [SETS][WAYS];
   int mpsel;
   int mlfsr;

   always #10 clk = ~clk;

   drrip_repl #(.SETS(SETS), .WAYS(WAYS), .LEADERS(LEADERS),
                .PSEL_W(PSEL_W), .RARE_BITS(RARE_BITS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_set(acc_set), .acc_hit(acc_hit), .acc_way(acc_way),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
      .vict_way(vict_way), .mode_bimodal(mode_bimodal));

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_vict(input int s);
      int mx = 0, v = 0;
      for (int w = 0; w < WAYS; w++) if (mv[s][w] > mx) mx = mv[s][w];
      for (int w = WAYS - 1; w >= 0; w--) if (mv[s][w] == mx) v = w;
      return v;
   endfunction

   function automatic int m_kind(input int s);  // 0 follower, 1 static leader, 2 bimodal leader
      if ((s & SEL_MASK) == 0) return 1;
      if ((s & SEL_MASK) == SEL_MASK) return 2;
      return 0;
   endfunction

   task automatic m_reset();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) mv[s][w] = 7;
      mpsel = (1 << (PSEL_W - 1)) - 1;
      mlfsr = 16'hACE1;
   endtask

   // One cycle: drive at negedge, compare outputs, apply model at posedge.
   task automatic cyc(input string tag, input bit av, input int aset, input bit ahit,
                      input int away, input bit fv, input int fset, input int fway);
      int delta, mx, ins, fb;
      bit bim;
      @(negedge clk);
      acc_valid = av; acc_set = 4'(aset); acc_hit = ahit; acc_way = 2'(away);
      fill_valid = fv; fill_set = 4'(fset); fill_way = 2'(fway);
      #2;
      chk({tag, " R2 victim"}, int'(vict_way), m_vict(aset));
      chk({tag, " R8 mode"}, int'(mode_bimodal), (mpsel >> (PSEL_W - 1)) & 1);
      @(posedge clk);
      mx = 0;
      for (int w = 0; w < WAYS; w++) if (mv[aset][w] > mx) mx = mv[aset][w];
      delta = 7 - mx;
      bim = (m_kind(fset) == 2) || (m_kind(fset) == 0 && mpsel > (PSEL_TOP >> 1));
      ins = (bim && ((mlfsr & ((1 << RARE_BITS) - 1)) == 0)) ? 6 : 7;
      if (av) begin
         if (ahit) mv[aset][away] = 0;
         else for (int w = 0; w < WAYS; w++) mv[aset][w] += delta;
         if (!ahit && m_kind(aset) == 1 && mpsel < PSEL_TOP) mpsel++;
         if (!ahit && m_kind(aset) == 2 && mpsel > 0) mpsel--;
      end
      if (fv) begin
         mv[fset][fway] = ins;
         fb = ((mlfsr >> 15) ^ (mlfsr >> 13) ^ (mlfsr >> 12) ^ (mlfsr >> 10)) & 1;
         mlfsr = ((mlfsr << 1) | fb) & 16'hFFFF;
      end
   endtask

   task automatic peek(input string tag, input int s, input int exp);
      cyc(tag, 0, s, 0, 0, 0, 0, 0);
      @(negedge clk);
      acc_set = 4'(s);
      #2;
      chk(tag, int'(vict_way), exp);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      acc_set = 4'd5;
      #2;
      chk("R1 reset victim", int'(vict_way), 0);
      chk("R1 reset mode", int'(mode_bimodal), 0);

      // R3 / R2 on follower set 1
      cyc("R3", 1, 1, 1, 0, 0, 0, 0);
      peek("R3 hit clears way0", 1, 1);
      cyc("R3", 1, 1, 1, 1, 0, 0, 0);
      cyc("R3", 1, 1, 1, 2, 0, 0, 0);
      peek("R2 only way3 at max", 1, 3);
      cyc("R3", 1, 1, 1, 3, 0, 0, 0);
      peek("R2 tie picks lowest", 1, 0);

      // R4: miss ages set 1, set 2 untouched
      cyc("R4", 1, 2, 1, 0, 0, 0, 0);
      peek("R4 set2 before", 2, 1);
      cyc("R4", 1, 1, 0, 0, 0, 0, 0);
      peek("R4 set1 aged to max", 1, 0);
      peek("R4 other set untouched", 2, 1);

      // R5: static fill in follower
      for (int w = 0; w < WAYS; w++) cyc("R3", 1, 1, 1, w, 0, 0, 0);
      cyc("R5", 0, 1, 0, 0, 1, 1, 2);
      peek("R5 static insert at 7", 1, 2);

      // R9: fill beats hit on the same way
      cyc("R9", 1, 1, 1, 2, 1, 1, 2);
      peek("R9 fill wins over hit", 1, 2);

      // R8: selector saturation
      for (int i = 0; i < 10; i++) cyc("R8", 1, 0, 0, 0, 0, 0, 0);
      peek("R8 probe", 5, m_vict(5));
      chk("R8 mode after static misses", int'(mode_bimodal), 1);

      // R7: static leader keeps inserting 7 while followers are bimodal
      for (int w = 0; w < WAYS; w++) cyc("R7", 1, 4, 1, w, 0, 0, 0);
      for (int i = 0; i < 12; i++) begin
         cyc("R7", 0, 4, 0, 0, 1, 4, 1);
         cyc("R7", 0, 4, 0, 0, 1, 4, 3);
         peek("R7 static leader insert", 4, 1);
      end

      // R6: bimodal leader and follower fills compared with the model
      for (int w = 0; w < WAYS; w++) cyc("R6", 1, 3, 1, w, 0, 0, 0);
      for (int i = 0; i < 12; i++) begin
         cyc("R6", 0, 3, 0, 0, 1, 3, 1);
         cyc("R6", 0, 3, 0, 0, 1, 3, 3);
         peek("R6 bimodal leader insert", 3, m_vict(3));
      end

      for (int i = 0; i < 7; i++) cyc("R8", 1, 3, 0, 0, 0, 0, 0);
      peek("R8 probe", 5, m_vict(5));
      chk("R8 top held at saturation", int'(mode_bimodal), 1);
      cyc("R8", 1, 3, 0, 0, 0, 0, 0);
      peek("R8 probe", 5, m_vict(5));
      chk("R8 mode back to static", int'(mode_bimodal), 0);
      for (int i = 0; i < 20; i++) cyc("R8", 1, 7, 0, 0, 0, 0, 0);
      for (int i = 0; i < 7; i++) cyc("R8", 1, 8, 0, 0, 0, 0, 0);
      peek("R8 probe", 5, m_vict(5));
      chk("R8 bottom held at saturation", int'(mode_bimodal), 0);

      // Random traffic against the model (R4, R6, R7, R9 interactions)
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         cyc("R6", r < 80, $urandom_range(0, SETS - 1), $urandom_range(0, 1),
             $urandom_range(0, WAYS - 1), r > 50, $urandom_range(0, SETS - 1),
             $urandom_range(0, WAYS - 1));
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule